// File: doc/BRIEF.md
# Four-Lane Binary32 Floor Unit

The block takes a 128-bit vector that holds four independent IEEE-754 binary32 values. It returns, in each lane, the largest integer not greater than that value, still encoded as binary32. Rounding always goes toward minus infinity. No external rounding-mode setting affects it, and it raises no flags of any kind.

A single mode input chooses how subnormal inputs are handled. When the mode is set, a subnormal input is replaced by a zero of the same sign before rounding. When the mode is clear, a subnormal input is rounded like any other tiny value.

The datapath is combinational and is followed by one register stage with a valid qualifier. A result therefore appears one clock after it is presented.

Top module: `vec_floor4`

## Requirements
- R1: Lane 0 occupies bits 127:96, lane 1 bits 95:64, lane 2 bits 63:32 and lane 3 bits 31:0. Each lane is computed only from its own 32 input bits.
- R2: For a positive lane with biased exponent from 127 to 149, every mantissa bit below the binary point is cleared. The sign and exponent are unchanged (3.2 gives 3.0).
- R3: For a negative lane with biased exponent from 127 to 149 and any nonzero bit below the binary point, the magnitude is truncated and then raised by one integer unit. A carry out of the mantissa increments the exponent: -1.5 gives -2.0 (0xC0000000), and 0xCAFFFFFF gives 0xCB000000.
- R4: A lane with biased exponent from 1 to 126 returns +0.0 (0x00000000) when positive and -1.0 (0xBF800000) when negative.
- R5: A lane with biased exponent from 150 to 254 passes through unchanged.
- R6: An infinity (exponent 255, mantissa 0) passes through unchanged. A NaN (exponent 255, mantissa nonzero) returns with its sign and payload kept and mantissa bit 22 set.
- R7: +0.0 and -0.0 pass through unchanged.
- R8: A subnormal lane (exponent 0, mantissa nonzero) returns a zero of its own sign when `flush_den` is 1. When `flush_den` is 0, it returns +0.0 if positive and -1.0 if negative.
- R9: `out_valid` equals `in_valid` of the previous cycle, and `res_vec` is loaded only in a cycle with `in_valid` high. Otherwise it holds its value.
- R10: While `rst_n` is low, `out_valid` is 0 and `res_vec` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Source vector is valid this cycle |
| src_vec | input | 128 | Four binary32 source lanes, lane 0 at the top |
| flush_den | input | 1 | 1: subnormal inputs count as signed zero |
| out_valid | output | 1 | Result vector is valid |
| res_vec | output | 128 | Four floored binary32 lanes |

## Verification
Each lane rounds independently, so subnormal flushing in one lane can coincide with a rounding carry into the exponent, or with NaN quieting, in a neighbouring lane. The bench provokes this in two ways. It packs mixed vectors: a subnormal next to 0xCAFFFFFF, next to a signalling NaN, next to -0.5, with `flush_den` both set and clear. It also pushes hundreds of random vectors whose exponents cluster around the binary point. Every lane of every result is judged on its own against a reference model that counts integer bits instead of masking fraction bits.

// File: rtl/vfl_pkg.sv
package vfl_pkg;
  localparam int EW      = 8;
  localparam int MW      = 23;
  localparam int FW      = 1 + EW + MW;
  localparam int BIAS    = (1 << (EW - 1)) - 1;
  localparam int INT_EXP = BIAS + MW;           // first biased exponent with no fraction bits
  localparam int EMAX    = (1 << EW) - 1;

  typedef enum logic [2:0] {
    C_ZERO, C_DEN, C_SMALL, C_FRAC, C_BIG, C_INF, C_NAN
  } lane_cls_e;

  // Mask of mantissa bits below the binary point for biased exponent e.
  function automatic logic [MW-1:0] frac_mask(input logic [EW-1:0] e);
    int fb;
    logic [MW-1:0] one;
    fb = INT_EXP - int'(e);
    if (fb < 0)  fb = 0;
    if (fb > MW) fb = MW;
    one = MW'(1);
    return (one << fb) - one;
  endfunction

  // Binary32 code for -1.0 and for signed zero.
  function automatic logic [FW-1:0] neg_one();
    return {1'b1, EW'(BIAS), {MW{1'b0}}};
  endfunction

  function automatic logic [FW-1:0] signed_zero(input logic s);
    return {s, {(FW-1){1'b0}}};
  endfunction
endpackage

// File: rtl/vfl_class.sv
module vfl_class
  import vfl_pkg::*;
(
  input  logic [FW-1:0] x,
  output lane_cls_e     cls
);
  logic [EW-1:0] e;
  logic [MW-1:0] m;
  assign e = x[FW-2 -: EW];
  assign m = x[MW-1:0];

  always_comb begin
    if (e == EW'(EMAX))          cls = (m != '0) ? C_NAN : C_INF;
    else if (e == '0)            cls = (m != '0) ? C_DEN : C_ZERO;
    else if (e >= EW'(INT_EXP))  cls = C_BIG;
    else if (e < EW'(BIAS))      cls = C_SMALL;
    else                         cls = C_FRAC;
  end
endmodule

// File: rtl/vfl_lane.sv
module vfl_lane
  import vfl_pkg::*;
(
  input  logic [FW-1:0] x,
  input  logic          flush,
  output logic [FW-1:0] y,
  output lane_cls_e     cls,
  output logic          rnd_up,
  output logic          exp_carry
);
  logic          s;
  logic [EW-1:0] e;
  logic [MW-1:0] m;
  logic [MW-1:0] mask;
  logic [MW-1:0] kept;
  logic [MW:0]   ulp;
  logic [MW-1:0] mant_up;
  logic          carry;
  logic          lost;

  assign s = x[FW-1];
  assign e = x[FW-2 -: EW];
  assign m = x[MW-1:0];

  vfl_class u_class (.x(x), .cls(cls));

  assign mask = frac_mask(e);
  assign kept = m & ~mask;
  assign lost = |(m & mask);
  assign ulp  = {1'b0, mask} + (MW+1)'(1);
  assign {carry, mant_up} = {1'b0, kept} + ulp;

  assign rnd_up    = (cls == C_FRAC) && s && lost;
  assign exp_carry = rnd_up && carry;

  always_comb begin
    unique case (cls)
      C_NAN:   y = {s, {EW{1'b1}}, 1'b1, m[MW-2:0]};
      C_INF,
      C_ZERO,
      C_BIG:   y = x;
      C_DEN:   y = flush ? signed_zero(s) : (s ? neg_one() : signed_zero(1'b0));
      C_SMALL: y = s ? neg_one() : signed_zero(1'b0);
      C_FRAC:  y = rnd_up ? {s, e + {{(EW-1){1'b0}}, carry}, mant_up} : {s, e, kept};
      default: y = x;
    endcase
  end
endmodule

// File: rtl/vec_floor4.sv
module vec_floor4
  import vfl_pkg::*;
#(
  parameter int LANES = 4,
  localparam int VW   = LANES * FW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [VW-1:0] src_vec,
  input  logic          flush_den,
  output logic          out_valid,
  output logic [VW-1:0] res_vec
);
  logic [VW-1:0]    lane_y;
  lane_cls_e        lane_cls [LANES];
  logic [LANES-1:0] lane_rnd;
  logic [LANES-1:0] lane_carry;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam int LO = VW - FW - i * FW;   // lane 0 at the top

    vfl_lane u_lane (
      .x         (src_vec[LO +: FW]),
      .flush     (flush_den),
      .y         (lane_y[LO +: FW]),
      .cls       (lane_cls[i]),
      .rnd_up    (lane_rnd[i]),
      .exp_carry (lane_carry[i])
    );

    p_nan_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && lane_cls[i] == C_NAN |=>
        res_vec[LO + FW - 2 -: EW] == EW'(EMAX) && res_vec[LO + MW - 1]);

    p_flush_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && flush_den && lane_cls[i] == C_DEN |=>
        res_vec[LO +: FW-1] == '0);

    p_round_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && lane_rnd[i] |=>
        res_vec[LO + FW - 1] && res_vec[LO + FW - 2 -: EW] >= EW'(BIAS));

    p_exp_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && lane_carry[i] |=> res_vec[LO +: MW] == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_vec   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) res_vec <= lane_y;
    end
  end

  p_valid_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(res_vec));
endmodule

// File: tb/vec_floor4_bench.sv
module vec_floor4_bench;
  localparam int CLK_P = 10;
  localparam int NT    = 16;

  localparam logic [31:0] T_IN [NT] = '{
    32'h404CCCCD, 32'hC04CCCCD, 32'hBFC00000, 32'h3FC00000,
    32'h3F000000, 32'hBF000000, 32'h80000000, 32'h00000000,
    32'h7F800000, 32'hFF800000, 32'h7F800001, 32'hFF812345,
    32'h4B000000, 32'hCAFFFFFF, 32'h00000001, 32'h80000001};
  localparam logic [31:0] T_EXP [NT] = '{
    32'h40400000, 32'hC0800000, 32'hC0000000, 32'h3F800000,
    32'h00000000, 32'hBF800000, 32'h80000000, 32'h00000000,
    32'h7F800000, 32'hFF800000, 32'h7FC00001, 32'hFFC12345,
    32'h4B000000, 32'hCB000000, 32'h00000000, 32'hBF800000};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] src_vec = '0;
  logic         flush_den = 1'b0;
  logic         out_valid;
  logic [127:0] res_vec;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  vec_floor4 u_vec_floor4 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .src_vec(src_vec),
    .flush_den(flush_den), .out_valid(out_valid), .res_vec(res_vec));

  always #(CLK_P/2) clk = ~clk;

  // Reference: count the integer part, bump it for negative fractions, re-encode.
  function automatic logic [31:0] ref_floor(input logic [31:0] x, input logic fl);
    logic s; int e; int k; int sh; longint full; longint ip; int p;
    s = x[31]; e = int'(x[30:23]);
    if (e == 255) return (x[22:0] != 0) ? (x | 32'h0040_0000) : x;
    if (e == 0) begin
      if (x[22:0] == 0) return x;
      if (fl) return {s, 31'b0};
      return s ? 32'hBF800000 : 32'h0;
    end
    if (e >= 150) return x;
    if (e < 127) return s ? 32'hBF800000 : 32'h0;
    k = e - 127; sh = 23 - k;
    full = longint'({1'b1, x[22:0]});
    ip = full >> sh;
    if (s && (full != (ip << sh))) ip = ip + 1;
    p = 0;
    for (int b = 0; b < 26; b++) if (ip[b]) p = b;
    return {s, 8'(127 + p), 23'((ip << (23 - p)) & 64'h7FFFFF)};
  endfunction

  task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [127:0] v, input logic fl);
    @(negedge clk);
    src_vec = v; flush_den = fl; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [127:0] ref_vec(input logic [127:0] v, input logic fl);
    logic [127:0] r;
    for (int l = 0; l < 4; l++) r[127 - 32*l -: 32] = ref_floor(v[127 - 32*l -: 32], fl);
    return r;
  endfunction

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] v, held;
    // R10 reset state
    repeat (2) @(negedge clk);
    check("R10 reset res", res_vec, '0);
    check("R10 reset valid", {127'b0, out_valid}, '0);
    rst_n = 1'b1;

    // R1..R8 table, four lanes per vector, lane 0 first (R1 lane order)
    for (int g = 0; g < NT/4; g++) begin
      logic [127:0] e4;
      for (int l = 0; l < 4; l++) begin
        v[127 - 32*l -: 32]  = T_IN[4*g + l];
        e4[127 - 32*l -: 32] = T_EXP[4*g + l];
      end
      apply(v, 1'b0);
      check("R1-table R2 R3 R4 R5 R6 R7 R8", res_vec, e4);
      check("R9 out_valid after in_valid", {127'b0, out_valid}, 128'd1);
    end

    // R8 subnormals with flush set: signed zero
    apply({32'h00000001, 32'h80000001, 32'h807FFFFF, 32'h007FFFFF}, 1'b1);
    check("R8 flush", res_vec, {32'h0, 32'h80000000, 32'h80000000, 32'h0});

    // R1 lane independence: same values rotated across lanes
    apply({32'hCAFFFFFF, 32'h80000001, 32'h7F800001, 32'hBF000000}, 1'b1);
    check("R1 mix flush", res_vec, {32'hCB000000, 32'h80000000, 32'h7FC00001, 32'hBF800000});
    apply({32'h80000001, 32'h7F800001, 32'hBF000000, 32'hCAFFFFFF}, 1'b0);
    check("R1 mix noflush", res_vec, {32'hBF800000, 32'h7FC00001, 32'hBF800000, 32'hCB000000});

    // R9 hold while in_valid low
    held = res_vec;
    @(negedge clk);
    src_vec = {4{32'hC04CCCCD}};
    @(negedge clk);
    check("R9 hold res", res_vec, held);
    check("R9 valid low", {127'b0, out_valid}, '0);

    // R2 R3 R4 R5 random sweep near the binary point
    for (int n = 0; n < 400; n++) begin
      logic fl;
      for (int l = 0; l < 4; l++) begin
        logic [31:0] w;
        w = $urandom;
        if (n % 4 != 0) w[30:23] = 8'(120 + $urandom_range(0, 35));
        v[127 - 32*l -: 32] = w;
      end
      fl = n[0];
      apply(v, fl);
      check("R2 R3 R4 R5 random", res_vec, ref_vec(v, fl));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule